// File: doc/BRIEF.md
# LED Matrix Scan Engine with Duty Dimming and Flash Gating

The block refreshes a 20-column by 14-row LED matrix one row at a time. The rows form two banks of seven: the first bank serves character positions 0 to 3 and the second serves positions 4 to 7. Each character is five adjacent columns wide. Every row is lit for a fixed period of `ROW_CLKS` clocks. While one row is shown, the engine asks an upstream column-pattern source for the pattern of the next row. At the row boundary it switches the row select and the column pattern on the same clock edge. A full refresh of all eight characters takes fourteen row periods.

Brightness is set by how long the columns stay on within each row period. The peak drive does not change. A slow square wave, with a 50% duty cycle, is taken from the frame count. This wave can gate the columns of selected characters (flash) or of every column (blink). The pattern source connects through a valid/ready stream. The stream runs one row ahead of the row on display and holds at most one pattern. Brightness, flash and blink are plain level inputs and take effect at once.

Top module: `matrix_scan`

## Requirements
- R1: After reset, `row_sel` selects row 0 (value 1), `col_en` is all zero, `pat_ready` is 1 and `pat_idx` is 1.
- R2: `row_sel` is one-hot. It advances one row every `ROW_CLKS` clocks, in the order 0, 1, ..., 13, and then wraps back to 0. Rows 0 to 6 form bank 0 and rows 7 to 13 form bank 1.
- R3: `pat_idx` always names the row after the one on display, wrapping from 13 to 0. `pat_ready` is high while no pattern is held. A pattern accepted (`pat_valid` and `pat_ready` both high) before the last clock of a row period is held, and `pat_ready` stays low until the next row boundary. At that boundary the held pattern is shown. A pattern accepted on the last clock of a row period is shown at once in the next row. Back-pressure: the source keeps `pat_valid` and `pat_data` stable until the pattern is accepted.
- R4: If no pattern has been accepted for a row by its boundary, every column is off for that whole row.
- R5: Columns are off on the first clock (phase 0) and the last clock (phase `ROW_CLKS`-1) of every row period.
- R6: `bright` code k lights the columns at phases 1 to L. L = floor((`ROW_CLKS`-2)*P/100), where P for codes 0 to 7 is 100, 80, 53, 40, 27, 20, 13 and 0. Code 0 therefore lights every phase except the two guard clocks.
- R7: With `bright` = 7, `col_en` stays all zero.
- R8: Column c of a row in bank b belongs to character 4*b + c/5. When `flash_en` is 1 and that character's bit in `flash_bits` is 1, the column is lit only while the flash wave is high.
- R9: When `blink` is 1, every column is lit only while the flash wave is high, whatever `flash_en` and `flash_bits` hold.
- R10: The flash wave is high after reset. It toggles at the end of every `FLASH_HALF_FRAMES` frames, where a frame is 14 row periods, so each half of the wave lasts the same time.
- R11: When `flash_en` is 0 and `blink` is 0, `flash_bits` has no effect on `col_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bright | input | 3 | Brightness code, 0 = brightest, 7 = off |
| flash_en | input | 1 | Enables per-character flashing |
| blink | input | 1 | Gates all columns with the flash wave |
| flash_bits | input | 8 | One flash bit per character position |
| pat_valid | input | 1 | Pattern stream valid |
| pat_ready | output | 1 | Pattern stream ready |
| pat_data | input | 20 | Column pattern for row `pat_idx`, bit c = column c |
| pat_idx | output | 4 | Row whose pattern is being requested |
| row_sel | output | 14 | One-hot row select |
| col_en | output | 20 | Column enables |

## Verification
The hardest case to reach from the ports is a pattern that arrives on the very last clock of a row period while the holding register is empty. That pattern must bypass the buffer and appear with the new row. A source mode in the bench raises `pat_valid` only when its own model phase counter reaches the final clock, so every row is fed through this path. Other source modes withhold data entirely, to reach the R4 blank rows, or offer data in pseudo-random bursts. The flash and blink phases run for several frames each, so that both levels of the wave and its toggles are compared cycle by cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_COLS        = 20;
  localparam int ROWS_PER_BANK   = 7;
  localparam int NUM_BANKS       = 2;
  localparam int COLS_PER_DIGIT  = 5;
  localparam int NUM_ROWS        = ROWS_PER_BANK * NUM_BANKS;
  localparam int DIGITS_PER_BANK = NUM_COLS / COLS_PER_DIGIT;
  localparam int NUM_DIGITS      = DIGITS_PER_BANK * NUM_BANKS;
  localparam int ROW_W           = $clog2(NUM_ROWS);

  // Lit length, in clocks, for a brightness code, out of (row_clks - 2) usable clocks.
  function automatic int unsigned duty_len(input int unsigned code, input int unsigned row_clks);
    int unsigned pct;
    case (code)
      0: pct = 100;
      1: pct = 80;
      2: pct = 53;
      3: pct = 40;
      4: pct = 27;
      5: pct = 20;
      6: pct = 13;
      default: pct = 0;
    endcase
    return ((row_clks - 2) * pct) / 100;
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int ROW_CLKS    = 64,
  parameter int NROWS       = 14,
  parameter int HALF_FRAMES = 2,
  localparam int PW = $clog2(ROW_CLKS),
  localparam int RW = $clog2(NROWS),
  localparam int FW = $clog2(HALF_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic [RW-1:0] row,
  output logic          row_end,
  output logic          wave
);
  logic [FW-1:0] fcnt;
  logic          last_row;

  assign row_end  = (phase == PW'(ROW_CLKS - 1));
  assign last_row = (row == RW'(NROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      row   <= '0;
      fcnt  <= '0;
      wave  <= 1'b1;
    end else if (row_end) begin
      phase <= '0;
      row   <= last_row ? '0 : row + RW'(1);
      if (last_row) begin
        if (fcnt == FW'(HALF_FRAMES - 1)) begin
          fcnt <= '0;
          wave <= ~wave;
        end else begin
          fcnt <= fcnt + FW'(1);
        end
      end
    end else begin
      phase <= phase + PW'(1);
    end
  end
endmodule

// File: rtl/pattern_buffer.sv
module pattern_buffer #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_end,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic [WIDTH-1:0] shown
);
  logic [WIDTH-1:0] held;
  logic             full;

  assign in_ready = ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= '0;
      full  <= 1'b0;
      shown <= '0;
    end else if (row_end) begin
      full <= 1'b0;
      if (full)          shown <= held;
      else if (in_valid) shown <= in_data;
      else               shown <= '0;
    end else if (in_valid && !full) begin
      held <= in_data;
      full <= 1'b1;
    end
  end
endmodule

// File: rtl/column_gate.sv
module column_gate
  import scan_pkg::*;
#(
  parameter int ROW_CLKS = 64,
  localparam int PW = $clog2(ROW_CLKS)
) (
  input  logic [PW-1:0]         phase,
  input  logic [2:0]            bright,
  input  logic                  bank,
  input  logic                  flash_en,
  input  logic                  blink,
  input  logic [NUM_DIGITS-1:0] flash_bits,
  input  logic                  wave,
  input  logic [NUM_COLS-1:0]   pattern,
  output logic [NUM_COLS-1:0]   col_en
);
  logic [PW-1:0] len_tbl [8];
  logic [PW-1:0] on_len;
  logic          lit;

  for (genvar k = 0; k < 8; k++) begin : g_len
    assign len_tbl[k] = PW'(duty_len(k, ROW_CLKS));
  end

  assign on_len = len_tbl[bright];
  assign lit = (phase != '0) && (phase != PW'(ROW_CLKS - 1)) && (phase <= on_len);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int DL = c / COLS_PER_DIGIT;
    logic fbit, gated;
    assign fbit   = bank ? flash_bits[DIGITS_PER_BANK + DL] : flash_bits[DL];
    assign gated  = blink | (flash_en & fbit);
    assign col_en[c] = pattern[c] & lit & (~gated | wave);
  end
endmodule

// File: rtl/matrix_scan.sv
module matrix_scan
  import scan_pkg::*;
#(
  parameter int ROW_CLKS          = 64,
  parameter int FLASH_HALF_FRAMES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            bright,
  input  logic                  flash_en,
  input  logic                  blink,
  input  logic [NUM_DIGITS-1:0] flash_bits,
  input  logic                  pat_valid,
  output logic                  pat_ready,
  input  logic [NUM_COLS-1:0]   pat_data,
  output logic [ROW_W-1:0]      pat_idx,
  output logic [NUM_ROWS-1:0]   row_sel,
  output logic [NUM_COLS-1:0]   col_en
);
  localparam int PW = $clog2(ROW_CLKS);

  logic [PW-1:0]       phase;
  logic [ROW_W-1:0]    row;
  logic                row_end;
  logic                wave;
  logic                bank;
  logic [NUM_COLS-1:0] shown;

  scan_timer #(
    .ROW_CLKS(ROW_CLKS), .NROWS(NUM_ROWS), .HALF_FRAMES(FLASH_HALF_FRAMES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .row(row), .row_end(row_end), .wave(wave)
  );

  pattern_buffer #(.WIDTH(NUM_COLS)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .row_end(row_end), .in_valid(pat_valid),
    .in_ready(pat_ready), .in_data(pat_data), .shown(shown)
  );

  column_gate #(.ROW_CLKS(ROW_CLKS)) u_gate (
    .phase(phase), .bright(bright), .bank(bank), .flash_en(flash_en), .blink(blink),
    .flash_bits(flash_bits), .wave(wave), .pattern(shown), .col_en(col_en)
  );

  assign bank    = (row >= ROW_W'(ROWS_PER_BANK));
  assign pat_idx = (row == ROW_W'(NUM_ROWS - 1)) ? '0 : row + ROW_W'(1);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_sel[r] = (row == ROW_W'(r));
  end
endmodule

// File: rtl/matrix_scan_checker.sv
module matrix_scan_checker #(
  parameter int NROWS = 14,
  parameter int NCOLS = 20,
  parameter int IW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NROWS-1:0] row_sel,
  input logic [NCOLS-1:0] col_en,
  input logic [IW-1:0]    pat_idx,
  input logic             pat_valid,
  input logic             pat_ready,
  input logic [2:0]       bright,
  input logic             row_end
);
  p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(row_sel));

  p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_sel) |-> row_sel == {$past(row_sel[NROWS-2:0]), $past(row_sel[NROWS-1])});

  p_idx_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(row_sel) |-> $stable(pat_idx));

  p_hold_until_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && pat_ready && !row_end) |=> !pat_ready);

  p_switch_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_sel) |-> col_en == '0);

  p_off_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bright == 3'd7 |-> col_en == '0);
endmodule

bind matrix_scan matrix_scan_checker #(
  .NROWS(scan_pkg::NUM_ROWS), .NCOLS(scan_pkg::NUM_COLS), .IW(scan_pkg::ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .col_en(col_en), .pat_idx(pat_idx),
  .pat_valid(pat_valid), .pat_ready(pat_ready), .bright(bright), .row_end(row_end)
);

// File: tb/matrix_scan_tb.sv
`timescale 1ns/1ps
module matrix_scan_tb;
  localparam int RC = 64;
  localparam int HALF = 2;
  localparam int NR = 14;
  localparam int NC = 20;
  localparam int FRAME = NR * RC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    bright = 3'd0;
  logic          flash_en = 1'b0, blink = 1'b0;
  logic [7:0]    flash_bits = 8'h00;
  logic          pat_valid = 1'b0;
  logic          pat_ready;
  logic [NC-1:0] pat_data = '0;
  logic [3:0]    pat_idx;
  logic [NR-1:0] row_sel;
  logic [NC-1:0] col_en;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  int src_mode = 0;
  logic [19:0] lfsr = 20'h5A3C1;

  // behavioural model state
  int m_phase, m_row, m_fcnt;
  bit m_wave, m_full, m_empty, acc_last;
  logic [NC-1:0] m_buf, m_disp;

  matrix_scan #(.ROW_CLKS(RC), .FLASH_HALF_FRAMES(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bright(bright), .flash_en(flash_en), .blink(blink),
    .flash_bits(flash_bits), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_data(pat_data), .pat_idx(pat_idx), .row_sel(row_sel), .col_en(col_en)
  );

  always #2 clk = ~clk;

  function automatic int pct_of(input int code);
    case (code)
      0: return 100; 1: return 80; 2: return 53; 3: return 40;
      4: return 27;  5: return 20; 6: return 13; default: return 0;
    endcase
  endfunction

  function automatic logic [NC-1:0] exp_cols();
    logic [NC-1:0] e;
    int len;
    bit lit;
    len = ((RC - 2) * pct_of(int'(bright))) / 100;
    lit = (m_phase >= 1) && (m_phase <= len) && (m_phase <= RC - 2);
    for (int c = 0; c < NC; c++) begin
      int dig;
      bit g;
      dig = (m_row >= 7 ? 4 : 0) + c / 5;
      g = blink || (flash_en && flash_bits[dig]);
      e[c] = m_disp[c] && lit && (!g || m_wave);
    end
    return e;
  endfunction

  function automatic string col_tag();
    if (m_phase == 0 || m_phase == RC - 1) return "R5";
    if (bright == 3'd7) return "R7";
    if (m_empty) return "R4";
    if (blink) return "R9,R10";
    if (flash_en) return "R8";
    if (flash_bits != 0) return "R11";
    return "R6";
  endfunction

  // reference model update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_row = 0; m_fcnt = 0; m_wave = 1; m_full = 0;
      m_empty = 1; m_buf = '0; m_disp = '0; acc_last = 0;
    end else begin
      bit hs;
      hs = pat_valid && !m_full;
      if (m_phase == RC - 1) begin
        if (m_full) begin m_disp = m_buf; m_empty = 0; end
        else if (pat_valid) begin m_disp = pat_data; m_empty = 0; end
        else begin m_disp = '0; m_empty = 1; end
        m_full = 0;
        m_phase = 0;
        if (m_row == NR - 1) begin
          m_row = 0;
          m_fcnt++;
          if (m_fcnt == HALF) begin m_fcnt = 0; m_wave = !m_wave; end
        end else m_row++;
      end else begin
        if (hs) begin m_buf = pat_data; m_full = 1; end
        m_phase++;
      end
      acc_last = hs;
    end
  end

  // pattern source, obeys hold-until-accepted
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
    if (!rst_n) pat_valid = 0;
    else if (!(pat_valid && !acc_last)) begin
      case (src_mode)
        0: pat_valid = 1;
        1: pat_valid = 0;
        2: pat_valid = lfsr[3];
        default: pat_valid = (m_phase == RC - 1);
      endcase
      pat_data = lfsr ^ {16'h0, pat_idx};
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NR-1:0] er;
      er = '0;
      er[m_row] = 1'b1;
      check("R2", "row_sel", 32'(row_sel), 32'(er));
      check("R3", "pat_idx", 32'(pat_idx), 32'((m_row + 1) % NR));
      check("R3", "pat_ready", 32'(pat_ready), 32'(!m_full));
      check(col_tag(), "col_en", 32'(col_en), 32'(exp_cols()));
    end
  end

  task automatic run(input int mode, input int b, input bit fe, input bit bl, input logic [7:0] fb, input int frames);
    @(posedge clk); #1;
    src_mode = mode; bright = 3'(b); flash_en = fe; blink = bl; flash_bits = fb;
    repeat (frames * FRAME) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "row_sel", 32'(row_sel), 32'd1);
    check("R1", "col_en", 32'(col_en), 32'd0);
    check("R1", "pat_ready", 32'(pat_ready), 32'd1);
    check("R1", "pat_idx", 32'(pat_idx), 32'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    run(0, 0, 0, 0, 8'h00, 2);            // R2 R3 R5 R6 full brightness
    for (int b = 1; b < 8; b++) run(0, b, 0, 0, 8'h00, 1);  // R6 R7 sweep
    run(0, 0, 1, 0, 8'hA5, 9);            // R8 R10 flash
    run(0, 2, 0, 0, 8'hFF, 2);            // R11 flash bits ignored
    run(0, 0, 0, 1, 8'h00, 9);            // R9 blink
    run(1, 0, 0, 0, 8'h00, 2);            // R4 underflow
    run(2, 1, 1, 0, 8'h3C, 4);            // R3 bursty source
    run(3, 0, 0, 0, 8'h00, 3);            // R3 boundary arrivals
    run(0, 0, 0, 0, 8'h00, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule